// File: doc/BRIEF.md
# Capture/Compare Timer with Split Mode

A timer/counter for a peripheral subsystem. In timer mode a prescaled time base drives it. In counter mode it counts edges seen on an external pin. Its configuration comes in on plain input buses, which the surrounding register file holds, and it reports through four sticky flags that a per-flag clear input resets.

Timer mode offers two functions.
- In capture/reload, the selected pin edges latch the running count into a capture register. Reaching all-ones reloads the count from a reload value.
- In compare, the count restarts from zero each time it matches a compare value.

The time base is either the system clock or a slow alternate clock. The slow clock is resynchronized, and each of its rising edges yields one system-clock-wide tick. A prescaler then divides the chosen base by a power of two.

A split-mode input divides the count into two halves. The upper half keeps every counter and capture function. The lower half always runs as a compare timer on the internal time base.

Top module: `cap_cmp_timer`

## Requirements
- R1: After reset, count, captureVal and all four flags are zero.
- R2: cfgDiv code d (0 to 7) makes the timer tick once every 2^d base ticks, giving ratios 1, 2, 4, 8, 16, 32, 64 and 128. Without the slow clock, the base tick is every system clock.
- R3: With cfgCounter=0 and cfgEdge not 00, a tick at all-ones loads reloadVal and sets ovfFlag. Any other tick increments the count.
- R4: With cfgCounter=0 and cfgEdge=00 (compare), a tick with count equal to compareVal sets cmpFlag and loads zero.
- R5: In timer mode, a pin edge selected by cfgEdge latches the count held before that cycle's update into captureVal and sets capFlag. The edge codes are 01 rising, 10falling and 11 both. An edge that is not selected is ignored. The capture takes effect on the third rising clock edge after the pin changes.
- R6: With cfgCounter=1, the count advances once per selected pin edge, and no capture occurs. Code 00 disables counting.
- R7: With cfgSlowClk=1, each rising edge of slowClk is one base tick. A steady level of slowClk produces no ticks.
- R8: With cfgSplit=1, the upper half behaves as in R3 to R6 at half width, using the upper halves of reloadVal and compareVal, and sets ovfFlag or cmpFlag. The lower half always counts timer ticks in compare mode against compareVal's lower half: on a match it wraps to zero and sets cmpLoFlag, even in counter mode.
- R9: With cfgSplit=1, a capture stores the upper half of the count in the upper half of captureVal and zero in the lower half.
- R10: clrFlags bit 0 clears ovfFlag, bit 1 clears cmpFlag, bit 2 clears capFlag and bit 3 clears cmpLoFlag. A set in the same cycle wins.
- R11: With runEn=0 the count does not change and the prescaler holds at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Enables counting, capture and the prescaler |
| cfgSplit | input | 1 | 0: single full-width count; 1: two halves |
| cfgCounter | input | 1 | 0: timer mode; 1: pin-edge counter mode |
| cfgEdge | input | 2 | Edge/function select (00 none/compare, 01 rise, 10 fall, 11 both) |
| cfgDiv | input | DIV_W | Prescale exponent |
| cfgSlowClk | input | 1 | Use slowClk rising edges as the time base |
| reloadVal | input | 2*HALF_W | Value loaded on overflow |
| compareVal | input | 2*HALF_W | Compare match value |
| clrFlags | input | 4 | Per-flag clear strobes |
| capPin | input | 1 | External capture / count pin (asynchronous) |
| slowClk | input | 1 | Slow alternate clock (asynchronous) |
| count | output | 2*HALF_W | Current count |
| captureVal | output | 2*HALF_W | Last captured count |
| ovfFlag | output | 1 | Overflow flag |
| cmpFlag | output | 1 | Compare match flag (full width or upper half) |
| capFlag | output | 1 | Capture flag |
| cmpLoFlag | output | 1 | Lower-half compare flag (split mode) |

## Verification
The bench builds the block with HALF_W=4, so the count is 8 bits wide and each half is 4 bits. It keeps DIV_W=3 and SYNC_STAGES=2. At this width a full wrap to the reload value takes 256 ticks. A half-width overflow in split mode takes 16 ticks. All eight prescale ratios can therefore be reached, together with overflow, compare restart and split-mode wrap, in a few hundred cycles each. The two-stage synchronizer fixes pin and slow-clock latency at a known three edges, so capture values can be predicted exactly.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam logic [1:0] EDGE_NONE = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

  typedef struct packed {
    logic hiStep;     // advance full count or upper half
    logic loStep;     // advance lower half (split mode)
    logic hiCompare;  // upper/full count runs as compare timer
    logic capStb;     // latch count into capture register
  } strobe_t;
endpackage

// File: rtl/cct_sync.sv
module cct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
    end else begin
      sh[0] <= d;
      for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/cct_ctrl.sv
module cct_ctrl
  import cct_pkg::*;
#(
  parameter int DIV_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             runEn,
  input  logic             cfgSplit,
  input  logic             cfgCounter,
  input  logic [1:0]       cfgEdge,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             cfgSlowClk,
  input  logic             capPin,
  input  logic             slowClk,
  output strobe_t          stb
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic pinS, pinPrev, slowS, slowPrev;

  cct_sync #(.STAGES(SYNC_STAGES)) uPinSync  (.clk(clk), .rst_n(rst_n), .d(capPin),  .q(pinS));
  cct_sync #(.STAGES(SYNC_STAGES)) uSlowSync (.clk(clk), .rst_n(rst_n), .d(slowClk), .q(slowS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pinPrev  <= 1'b0;
      slowPrev <= 1'b0;
    end else begin
      pinPrev  <= pinS;
      slowPrev <= slowS;
    end
  end

  logic pinRise, pinFall, pinHit, slowRise, baseTick;
  assign pinRise  = pinS & ~pinPrev;
  assign pinFall  = ~pinS & pinPrev;
  assign pinHit   = (cfgEdge[0] & pinRise) | (cfgEdge[1] & pinFall);
  assign slowRise = slowS & ~slowPrev;
  assign baseTick = cfgSlowClk ? slowRise : 1'b1;

  // prescaler: wraps after 2^cfgDiv base ticks
  logic [PRE_W:0]   divFull;
  logic [PRE_W-1:0] divMask, preCnt;
  logic             preWrap, timerTick;
  assign divFull   = (PRE_W+1)'(1) << cfgDiv;
  assign divMask   = divFull[PRE_W-1:0] - 1'b1;
  assign preWrap   = preCnt >= divMask;
  assign timerTick = runEn && baseTick && preWrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        preCnt <= '0;
    else if (!runEn)   preCnt <= '0;
    else if (baseTick) preCnt <= preWrap ? '0 : preCnt + 1'b1;
  end

  always_comb begin
    stb.hiStep    = runEn && (cfgCounter ? pinHit : timerTick);
    stb.loStep    = cfgSplit && timerTick;
    stb.hiCompare = !cfgCounter && (cfgEdge == EDGE_NONE);
    stb.capStb    = runEn && !cfgCounter && pinHit;
  end
endmodule

// File: rtl/cct_datapath.sv
module cct_datapath
  import cct_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             stb,
  input  logic                cfgSplit,
  input  logic [2*HALF_W-1:0] reloadVal,
  input  logic [2*HALF_W-1:0] compareVal,
  input  logic [3:0]          clrFlags,
  output logic [2*HALF_W-1:0] count,
  output logic [2*HALF_W-1:0] captureVal,
  output logic                ovfFlag,
  output logic                cmpFlag,
  output logic                capFlag,
  output logic                cmpLoFlag
);
  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0]  cnt, nextCnt, capNext;
  logic [HALF_W-1:0] hiCnt, loCnt;
  logic              setOvf, setCmp, setCmpLo;

  assign hiCnt = cnt[CNT_W-1:HALF_W];
  assign loCnt = cnt[HALF_W-1:0];

  always_comb begin
    nextCnt  = cnt;
    setOvf   = 1'b0;
    setCmp   = 1'b0;
    setCmpLo = 1'b0;
    if (!cfgSplit) begin
      if (stb.hiStep) begin
        if (stb.hiCompare) begin
          if (cnt == compareVal) begin nextCnt = '0; setCmp = 1'b1; end
          else nextCnt = cnt + 1'b1;
        end else if (cnt == {CNT_W{1'b1}}) begin
          nextCnt = reloadVal; setOvf = 1'b1;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
    end else begin
      if (stb.hiStep) begin
        if (stb.hiCompare) begin
          if (hiCnt == compareVal[CNT_W-1:HALF_W]) begin
            nextCnt[CNT_W-1:HALF_W] = '0; setCmp = 1'b1;
          end else nextCnt[CNT_W-1:HALF_W] = hiCnt + 1'b1;
        end else if (hiCnt == {HALF_W{1'b1}}) begin
          nextCnt[CNT_W-1:HALF_W] = reloadVal[CNT_W-1:HALF_W]; setOvf = 1'b1;
        end else begin
          nextCnt[CNT_W-1:HALF_W] = hiCnt + 1'b1;
        end
      end
      if (stb.loStep) begin
        if (loCnt == compareVal[HALF_W-1:0]) begin
          nextCnt[HALF_W-1:0] = '0; setCmpLo = 1'b1;
        end else nextCnt[HALF_W-1:0] = loCnt + 1'b1;
      end
    end
    capNext = cfgSplit ? {hiCnt, {HALF_W{1'b0}}} : cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      captureVal <= '0;
      ovfFlag    <= 1'b0;
      cmpFlag    <= 1'b0;
      capFlag    <= 1'b0;
      cmpLoFlag  <= 1'b0;
    end else begin
      cnt <= nextCnt;
      if (stb.capStb) captureVal <= capNext;
      ovfFlag   <= (ovfFlag   & ~clrFlags[0]) | setOvf;
      cmpFlag   <= (cmpFlag   & ~clrFlags[1]) | setCmp;
      capFlag   <= (capFlag   & ~clrFlags[2]) | stb.capStb;
      cmpLoFlag <= (cmpLoFlag & ~clrFlags[3]) | setCmpLo;
    end
  end

  assign count = cnt;
endmodule

// File: rtl/cap_cmp_timer.sv
module cap_cmp_timer
  import cct_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int DIV_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                runEn,
  input  logic                cfgSplit,
  input  logic                cfgCounter,
  input  logic [1:0]          cfgEdge,
  input  logic [DIV_W-1:0]    cfgDiv,
  input  logic                cfgSlowClk,
  input  logic [2*HALF_W-1:0] reloadVal,
  input  logic [2*HALF_W-1:0] compareVal,
  input  logic [3:0]          clrFlags,
  input  logic                capPin,
  input  logic                slowClk,
  output logic [2*HALF_W-1:0] count,
  output logic [2*HALF_W-1:0] captureVal,
  output logic                ovfFlag,
  output logic                cmpFlag,
  output logic                capFlag,
  output logic                cmpLoFlag
);
  strobe_t stb;

  cct_ctrl #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rst_n(rst_n), .runEn(runEn), .cfgSplit(cfgSplit),
    .cfgCounter(cfgCounter), .cfgEdge(cfgEdge), .cfgDiv(cfgDiv),
    .cfgSlowClk(cfgSlowClk), .capPin(capPin), .slowClk(slowClk), .stb(stb)
  );

  cct_datapath #(.HALF_W(HALF_W)) uDp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .cfgSplit(cfgSplit),
    .reloadVal(reloadVal), .compareVal(compareVal), .clrFlags(clrFlags),
    .count(count), .captureVal(captureVal), .ovfFlag(ovfFlag),
    .cmpFlag(cmpFlag), .capFlag(capFlag), .cmpLoFlag(cmpLoFlag)
  );
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int HALF_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfgSplit,
  input logic                cfgCounter,
  input logic [1:0]          cfgEdge,
  input logic [2*HALF_W-1:0] reloadVal,
  input logic [2*HALF_W-1:0] count,
  input logic [2*HALF_W-1:0] captureVal,
  input logic                ovfFlag,
  input logic                cmpFlag,
  input logic                capFlag,
  input logic                cmpLoFlag
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (count == '0 && captureVal == '0 && !ovfFlag && !cmpFlag && !capFlag && !cmpLoFlag));

  a_r3_ovf_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovfFlag) && !$past(cfgSplit)) |-> count == $past(reloadVal));

  a_r4_cmp_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmpFlag) |-> count[2*HALF_W-1:HALF_W] == '0);

  a_r5_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(capFlag) && !$past(cfgSplit)) |-> captureVal == $past(count));

  a_r6_counter_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgCounter && cfgEdge == 2'b00 && !cfgSplit) |=> $stable(count));
endmodule

bind cap_cmp_timer cct_checker #(.HALF_W(HALF_W)) uChk (
  .clk(clk), .rst_n(rst_n), .cfgSplit(cfgSplit), .cfgCounter(cfgCounter),
  .cfgEdge(cfgEdge), .reloadVal(reloadVal), .count(count),
  .captureVal(captureVal), .ovfFlag(ovfFlag), .cmpFlag(cmpFlag),
  .capFlag(capFlag), .cmpLoFlag(cmpLoFlag)
);

// File: tb/sim_cap_cmp_timer.sv
module sim_cap_cmp_timer;
  localparam int HALF_W = 4;
  localparam int DIV_W  = 3;
  localparam int CNT_W  = 2 * HALF_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic runEn = 1'b0, cfgSplit = 1'b0, cfgCounter = 1'b0, cfgSlowClk = 1'b0;
  logic [1:0] cfgEdge = 2'b01;
  logic [DIV_W-1:0] cfgDiv = '0;
  logic [CNT_W-1:0] reloadVal = '0, compareVal = '0;
  logic [3:0] clrFlags = '0;
  logic capPin = 1'b0, slowClk = 1'b0;
  logic [CNT_W-1:0] count, captureVal;
  logic ovfFlag, cmpFlag, capFlag, cmpLoFlag;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cap_cmp_timer #(.HALF_W(HALF_W), .DIV_W(DIV_W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .runEn(runEn), .cfgSplit(cfgSplit),
    .cfgCounter(cfgCounter), .cfgEdge(cfgEdge), .cfgDiv(cfgDiv),
    .cfgSlowClk(cfgSlowClk), .reloadVal(reloadVal), .compareVal(compareVal),
    .clrFlags(clrFlags), .capPin(capPin), .slowClk(slowClk), .count(count),
    .captureVal(captureVal), .ovfFlag(ovfFlag), .cmpFlag(cmpFlag),
    .capFlag(capFlag), .cmpLoFlag(cmpLoFlag)
  );

  // {div, cycles, expected count}
  localparam logic [26:0] VEC [0:7] = '{
    {3'd0, 16'd10,  8'd10}, {3'd1, 16'd11,  8'd5},
    {3'd2, 16'd13,  8'd3},  {3'd3, 16'd20,  8'd2},
    {3'd4, 16'd50,  8'd3},  {3'd5, 16'd70,  8'd2},
    {3'd6, 16'd200, 8'd3},  {3'd7, 16'd300, 8'd2}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; runEn = 1'b0; cfgSplit = 1'b0; cfgCounter = 1'b0;
    cfgSlowClk = 1'b0; cfgEdge = 2'b01; cfgDiv = '0; reloadVal = '0;
    compareVal = '0; clrFlags = '0; capPin = 1'b0; slowClk = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // runEn high for exactly n rising edges; returns at a falling edge
  task automatic runFor(input int n);
    @(negedge clk);
    runEn = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    runEn = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); capPin = 1'b1;
      repeat (3) @(negedge clk);
      capPin = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    doReset();
    chk("R1 count", count, 0);
    chk("R1 capture", captureVal, 0);
    chk("R1 flags", {ovfFlag, cmpFlag, capFlag, cmpLoFlag}, 0);

    // R2 prescale table, R11 freeze when stopped
    for (int v = 0; v < 8; v++) begin
      doReset();
      cfgDiv = VEC[v][26:24];
      runFor(int'(VEC[v][23:8]));
      chk("R2 prescaled count", count, int'(VEC[v][7:0]));
      repeat (5) @(negedge clk);
      chk("R11 stopped count holds", count, int'(VEC[v][7:0]));
    end

    // R3 overflow reload, R10 flag clear
    doReset();
    reloadVal = 8'hF0;
    runFor(255);
    chk("R3 all-ones before wrap", count, 8'hFF);
    chk("R3 no ovf yet", ovfFlag, 0);
    runFor(1);
    chk("R3 reload value", count, 8'hF0);
    chk("R3 ovf set", ovfFlag, 1);
    clrFlags = 4'b0001;
    @(negedge clk); clrFlags = 4'b0000;
    @(negedge clk);
    chk("R10 ovf cleared", ovfFlag, 0);

    // R4 compare restart
    doReset();
    cfgEdge = 2'b00; compareVal = 8'd5;
    runFor(5);
    chk("R4 count at match", count, 5);
    chk("R4 no cmp yet", cmpFlag, 0);
    runFor(1);
    chk("R4 restart to zero", count, 0);
    chk("R4 cmp set", cmpFlag, 1);

    // R5 rising capture, falling ignored
    doReset();
    cfgEdge = 2'b01;
    @(negedge clk); runEn = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk); capPin = 1'b1;
    repeat (9) @(posedge clk);
    @(negedge clk);
    chk("R5 rise capture value", captureVal, 12);
    chk("R5 capFlag", capFlag, 1);
    capPin = 1'b0; clrFlags = 4'b0100;
    @(negedge clk); clrFlags = 4'b0000;
    repeat (5) @(negedge clk);
    chk("R5 falling ignored value", captureVal, 12);
    chk("R5 falling ignored flag", capFlag, 0);
    runEn = 1'b0;

    // R5 falling capture, rising ignored
    doReset();
    cfgEdge = 2'b10;
    @(negedge clk); runEn = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); capPin = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R5 rise ignored in fall mode", capFlag, 0);
    capPin = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R5 fall capture value", captureVal, 12);
    chk("R5 fall capFlag", capFlag, 1);
    runEn = 1'b0;

    // R6 counter mode
    doReset();
    cfgCounter = 1'b1; cfgEdge = 2'b11;
    @(negedge clk); runEn = 1'b1;
    pulses(3);
    runEn = 1'b0;
    chk("R6 both edges count", count, 6);
    chk("R6 no capture", capFlag, 0);
    doReset();
    cfgCounter = 1'b1; cfgEdge = 2'b10;
    @(negedge clk); runEn = 1'b1;
    pulses(3);
    runEn = 1'b0;
    chk("R6 falling edges count", count, 3);
    doReset();
    cfgCounter = 1'b1; cfgEdge = 2'b00;
    @(negedge clk); runEn = 1'b1;
    pulses(3);
    runEn = 1'b0;
    chk("R6 disabled counter", count, 0);

    // R7 slow clock
    doReset();
    cfgSlowClk = 1'b1;
    @(negedge clk); runEn = 1'b1;
    for (int i = 0; i < 5; i++) begin
      slowClk = 1'b1; repeat (4) @(negedge clk);
      slowClk = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    runEn = 1'b0;
    chk("R7 one tick per slow rise", count, 5);

    // R8 split mode timer
    doReset();
    cfgSplit = 1'b1; compareVal = 8'h03; reloadVal = 8'h50;
    runFor(10);
    chk("R8 halves after 10", count, 8'hA2);
    chk("R8 lower cmp flag", cmpLoFlag, 1);
    chk("R8 no ovf yet", ovfFlag, 0);
    runFor(6);
    chk("R8 upper reload", count, 8'h50);
    chk("R8 upper ovf", ovfFlag, 1);
    chk("R8 upper cmp idle", cmpFlag, 0);

    // R8 lower half keeps timing in counter mode
    doReset();
    cfgSplit = 1'b1; cfgCounter = 1'b1; compareVal = 8'h0F;
    runFor(7);
    chk("R8 lower counts in counter mode", count, 8'h07);

    // R9 split capture
    doReset();
    cfgSplit = 1'b1; compareVal = 8'h0F;
    @(negedge clk); runEn = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); capPin = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk); runEn = 1'b0;
    chk("R9 split capture", captureVal, 8'h60);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule